// File: doc/BRIEF.md
# Power-Managed Clock Mode Controller

This controller decides which oscillator clocks the device and whether the CPU and peripheral clock domains are gated. Four sources can be selected: the primary oscillator, the secondary (low-frequency timer) oscillator, a slow internal RC clock of about 31 kHz, and a fast 8 MHz internal oscillator behind a power-of-two postscaler. Every source can be used in a run variant, where CPU and peripherals are clocked, or in an idle variant, where only the peripherals are clocked. A sleep state stops every clock domain. Oscillators are modelled as an enable output paired with a ready input.

Software asks for a mode with a one-cycle `mode_req` strobe. A request that keeps the same oscillator takes effect on the next edge. A request for another oscillator first enables the target and leaves the clock mux on the old source until the target reports ready, so the mux never switches to a clock that is not running. In sleep, the slow RC clock stays on only while the watchdog needs it, and the secondary oscillator stays on only while the real-time clock needs it. A wake event in idle or sleep returns the controller to the run variant of the current source. The CPU clock comes back only after that source reports ready.

Top module: `pm_clock_ctrl`

## Requirements
- R1: After reset, `clk_sel` is 3 (fast internal) and `post_div` is 0. `hfosc_en` is high, and `cpu_clk_en` and `per_clk_en` stay low until `hfosc_rdy` is sampled high. Both enables rise on that sampling edge.
- R2: `clk_sel` codes the sources as 0 primary, 1 secondary, 2 slow RC, 3 fast internal. Whenever `cpu_clk_en` or `per_clk_en` is high, the enable of the source named by `clk_sel` is high.
- R3: A run-state request for a different source enables the target on the next edge and keeps the old source enabled. `clk_sel` holds its old value, with the CPU still clocked, until the target's ready input is sampled high. `clk_sel` changes on that edge.
- R4: In an idle variant, `cpu_clk_en` is low, `per_clk_en` is high, and the selected source stays enabled.
- R5: A run-state request for the current source does not switch the source. Its idle bit and `req_div` take effect on the next edge.
- R6: `post_div` carries the postscaler code n (divide by 2^n, n = 0..7) for the fast source. While the slow RC clock is selected and no switch is pending, `hfosc_en` is low.
- R7: In sleep, `cpu_clk_en`, `per_clk_en`, `pri_osc_en` and `hfosc_en` are low. `lfrc_en` equals `wdt_en` and `sec_osc_en` equals `rtc_en`.
- R8: `wdt_en` high forces `lfrc_en` high in every state, and `rtc_en` high forces `sec_osc_en` high in every state.
- R9: `wake` in idle or sleep returns to the run variant with `clk_sel` unchanged. `cpu_clk_en` rises only on an edge where the selected source's ready input is sampled high.
- R10: `mode_req` is ignored outside the run state, and `sleep_req` is ignored in sleep, in the wake-up wait and during a source switch.
- R11: When `sleep_req` and `mode_req` arrive together in the run state, the controller enters sleep and does not start the requested mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 1 | One-cycle strobe that requests a new mode |
| req_osc | input | 2 | Requested source (same coding as `clk_sel`) |
| req_div | input | 3 | Requested postscaler code for the fast source |
| req_idle | input | 1 | 1 requests the idle variant |
| sleep_req | input | 1 | Request to enter sleep |
| wake | input | 1 | Wake event |
| wdt_en | input | 1 | Watchdog needs the slow RC clock |
| rtc_en | input | 1 | Real-time clock needs the secondary oscillator |
| pri_rdy | input | 1 | Primary oscillator stable |
| sec_rdy | input | 1 | Secondary oscillator stable |
| lfrc_rdy | input | 1 | Slow RC clock stable |
| hfosc_rdy | input | 1 | Fast internal oscillator stable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| lfrc_en | output | 1 | Slow RC clock enable |
| hfosc_en | output | 1 | Fast internal oscillator enable |
| clk_sel | output | 2 | Clock mux select |
| post_div | output | 3 | Postscaler code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |

## Verification
The assertions check these invariants on every cycle:
- The selected source is enabled whenever a clock domain runs.
- The mux holds while a switch target is not ready.
- The fast oscillator is off under direct slow RC operation.
- Sleep gating is in force, and the feature flags keep their oscillators on.
- The CPU clock returns only after ready is sampled.

Only the bench's scenarios can show the exact sequences. These are which source a request ends on, that the idle bit and the divider apply on the next edge, and that ignored requests leave the outputs untouched. The same holds for the priority of sleep over a mode change, and for the reset wait on the fast oscillator.

// File: rtl/pm_clock_ctrl.sv
module pm_clock_ctrl #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_req,
  input  logic [1:0]       req_osc,
  input  logic [DIV_W-1:0] req_div,
  input  logic             req_idle,
  input  logic             sleep_req,
  input  logic             wake,
  input  logic             wdt_en,
  input  logic             rtc_en,
  input  logic             pri_rdy,
  input  logic             sec_rdy,
  input  logic             lfrc_rdy,
  input  logic             hfosc_rdy,
  output logic             pri_osc_en,
  output logic             sec_osc_en,
  output logic             lfrc_en,
  output logic             hfosc_en,
  output logic [1:0]       clk_sel,
  output logic [DIV_W-1:0] post_div,
  output logic             cpu_clk_en,
  output logic             per_clk_en
);
  localparam logic [1:0] OSC_SLOW = 2'd2;
  localparam logic [1:0] OSC_FAST = 2'd3;

  typedef enum logic [2:0] {ST_RUN, ST_IDLE, ST_SLEEP, ST_WAKE, ST_SWITCH} st_t;

  st_t              st;
  logic [1:0]       cur_osc, tgt_osc;
  logic [DIV_W-1:0] cur_div, tgt_div;
  logic             tgt_idle;

  logic [3:0] rdy_vec, en_vec;
  logic       sel_rdy, tgt_rdy;

  assign rdy_vec = {hfosc_rdy, lfrc_rdy, sec_rdy, pri_rdy};
  assign sel_rdy = rdy_vec[cur_osc];
  assign tgt_rdy = rdy_vec[tgt_osc];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_WAKE;
      cur_osc  <= OSC_FAST;
      cur_div  <= '0;
      tgt_osc  <= OSC_FAST;
      tgt_div  <= '0;
      tgt_idle <= 1'b0;
    end else begin
      case (st)
        ST_RUN:
          if (sleep_req) st <= ST_SLEEP;
          else if (mode_req) begin
            if (req_osc == cur_osc) begin
              cur_div <= req_div;
              st      <= req_idle ? ST_IDLE : ST_RUN;
            end else begin
              tgt_osc  <= req_osc;
              tgt_div  <= req_div;
              tgt_idle <= req_idle;
              st       <= ST_SWITCH;
            end
          end
        ST_IDLE:
          if (wake) st <= ST_WAKE;
          else if (sleep_req) st <= ST_SLEEP;
        ST_SLEEP:
          if (wake) st <= ST_WAKE;
        ST_WAKE:
          if (sel_rdy) st <= ST_RUN;
        ST_SWITCH:
          if (tgt_rdy) begin
            cur_osc <= tgt_osc;
            cur_div <= tgt_div;
            st      <= tgt_idle ? ST_IDLE : ST_RUN;
          end
        default: st <= ST_WAKE;
      endcase
    end
  end

  logic active, switching;
  assign active    = (st != ST_SLEEP);
  assign switching = (st == ST_SWITCH);

  assign en_vec = (active    ? (4'b0001 << cur_osc) : 4'b0000)
                | (switching ? (4'b0001 << tgt_osc) : 4'b0000)
                | {1'b0, wdt_en, rtc_en, 1'b0};

  assign {hfosc_en, lfrc_en, sec_osc_en, pri_osc_en} = en_vec;
  assign clk_sel    = cur_osc;
  assign post_div   = cur_div;
  assign cpu_clk_en = (st == ST_RUN) || switching;
  assign per_clk_en = (st == ST_RUN) || (st == ST_IDLE) || switching;

  p_sel_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en || per_clk_en) |-> {hfosc_en, lfrc_en, sec_osc_en, pri_osc_en}[clk_sel]);

  p_hold_mux_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (switching && !tgt_rdy) |=> $stable(clk_sel));

  p_fast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!switching && clk_sel == OSC_SLOW) |-> !hfosc_en);

  p_sleep_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP) |-> (!cpu_clk_en && !per_clk_en && !pri_osc_en && !hfosc_en));

  p_wdt_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_en |-> lfrc_en);

  p_rtc_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_en |-> sec_osc_en);

  p_cpu_after_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(sel_rdy));

  p_wake_same_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE) |=> $stable(clk_sel));
endmodule

// File: tb/tb_pm_clock_ctrl.sv
`timescale 1ns/1ps
module tb_pm_clock_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_req = 0, req_idle = 0, sleep_req = 0, wake = 0, wdt_en = 0, rtc_en = 0;
  logic [1:0] req_osc = 0;
  logic [2:0] req_div = 0;
  logic pri_rdy = 0, sec_rdy = 0, lfrc_rdy = 0, hfosc_rdy = 0;
  logic pri_osc_en, sec_osc_en, lfrc_en, hfosc_en, cpu_clk_en, per_clk_en;
  logic [1:0] clk_sel;
  logic [2:0] post_div;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm_clock_ctrl dut (.*);

  // Row: {req#, rdy{hf,lf,sec,pri}, wdt, rtc, mreq, osc, div, idle, sleep, wake,
  //       exp cpu, exp per, exp en{hf,lf,sec,pri}, exp sel, exp div}
  localparam int NV = 22;
  localparam logic [29:0] VEC [NV] = '{
    {4'd1,  4'b1000, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b1000,2'd3,3'd0}, // R1 fast ready ends reset wait
    {4'd5,  4'b1000, 1'b0,1'b0, 1'b1,2'd3,3'd2,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b1000,2'd3,3'd2}, // R5 same source, new divider
    {4'd3,  4'b1000, 1'b0,1'b0, 1'b1,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b1001,2'd3,3'd2}, // R3 start switch to primary
    {4'd3,  4'b1000, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b1001,2'd3,3'd2}, // R3 mux held, target not ready
    {4'd10, 4'b1001, 1'b0,1'b0, 1'b1,2'd1,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b0001,2'd0,3'd0}, // R10 request during switch ignored
    {4'd4,  4'b0001, 1'b0,1'b0, 1'b1,2'd0,3'd0,1'b1,1'b0,1'b0, 1'b0,1'b1,4'b0001,2'd0,3'd0}, // R4 primary idle
    {4'd9,  4'b0001, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,4'b0001,2'd0,3'd0}, // R9 wake from idle
    {4'd9,  4'b0001, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b0001,2'd0,3'd0}, // R9 back to run
    {4'd11, 4'b0001, 1'b1,1'b0, 1'b1,2'd2,3'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,4'b0100,2'd0,3'd0}, // R11 sleep wins
    {4'd8,  4'b0000, 1'b0,1'b1, 1'b1,2'd3,3'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,4'b0010,2'd0,3'd0}, // R8 rtc keeps sec on in sleep
    {4'd9,  4'b0000, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,4'b0001,2'd0,3'd0}, // R9 wake from sleep
    {4'd9,  4'b0000, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b0,4'b0001,2'd0,3'd0}, // R9 no ready, cpu stays off
    {4'd9,  4'b0001, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b0001,2'd0,3'd0}, // R9 ready, cpu back
    {4'd3,  4'b0001, 1'b0,1'b0, 1'b1,2'd2,3'd0,1'b1,1'b0,1'b0, 1'b1,1'b1,4'b0101,2'd0,3'd0}, // R3 switch to slow RC idle
    {4'd6,  4'b0101, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b0,1'b1,4'b0100,2'd2,3'd0}, // R6 slow RC direct, fast off
    {4'd9,  4'b0100, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b1, 1'b0,1'b0,4'b0100,2'd2,3'd0}, // R9 wake
    {4'd9,  4'b0100, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b0100,2'd2,3'd0}, // R9 run on slow RC
    {4'd3,  4'b0100, 1'b0,1'b0, 1'b1,2'd3,3'd7,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b1100,2'd2,3'd0}, // R3 switch to fast /128
    {4'd6,  4'b1100, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b1000,2'd3,3'd7}, // R6 postscaler code 7
    {4'd3,  4'b1000, 1'b0,1'b0, 1'b1,2'd1,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b1010,2'd3,3'd7}, // R3 switch to secondary
    {4'd2,  4'b1010, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b0,1'b0, 1'b1,1'b1,4'b0010,2'd1,3'd0}, // R2 secondary selected and on
    {4'd7,  4'b0010, 1'b0,1'b0, 1'b0,2'd0,3'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,4'b0000,2'd1,3'd0}  // R7 sleep, all sources off
  };

  function automatic logic [10:0] got_vec();
    return {cpu_clk_en, per_clk_en, hfosc_en, lfrc_en, sec_osc_en, pri_osc_en, clk_sel, post_div};
  endfunction

  task automatic check(input string tag, input logic [10:0] exp);
    checks++;
    if (got_vec() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got_vec(), exp);
    end
  endtask

  task automatic drive_idle();
    mode_req = 0; sleep_req = 0; wake = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    check("R1 reset state", {2'b00, 4'b1000, 2'd3, 3'd0});

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      {hfosc_rdy, lfrc_rdy, sec_rdy, pri_rdy} = v[25:22];
      wdt_en = v[21]; rtc_en = v[20]; mode_req = v[19]; req_osc = v[18:17];
      req_div = v[16:14]; req_idle = v[13]; sleep_req = v[12]; wake = v[11];
      step();
      check($sformatf("R%0d vector %0d", v[29:26], i), v[10:0]);
    end

    // R1: reset wait holds while the fast source is not ready
    drive_idle(); wdt_en = 0; rtc_en = 0;
    {hfosc_rdy, lfrc_rdy, sec_rdy, pri_rdy} = 4'b0000;
    rst_n = 0; step(); rst_n = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R1 waiting for fast ready", {2'b00, 4'b1000, 2'd3, 3'd0});
    end
    hfosc_rdy = 1; step();
    check("R1 cpu after fast ready", {2'b11, 4'b1000, 2'd3, 3'd0});

    // R8: watchdog flag keeps slow RC on in run
    wdt_en = 1; #1;
    check("R8 wdt in run", {2'b11, 4'b1100, 2'd3, 3'd0});
    wdt_en = 0;

    // R10: mode request in idle is ignored
    mode_req = 1; req_osc = 2'd3; req_div = 3'd0; req_idle = 1; step();
    check("R4 fast idle", {2'b01, 4'b1000, 2'd3, 3'd0});
    mode_req = 1; req_osc = 2'd0; req_idle = 0; pri_rdy = 1; step();
    check("R10 request in idle ignored", {2'b01, 4'b1000, 2'd3, 3'd0});
    drive_idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule